// File: doc/BRIEF.md
# Serial Character Transmitter with Holding Latch

The block turns bytes written over a parallel port into asynchronous serial frames on a single output line. A write strobe captures a byte into a holding latch. A three-state controller (idle, load, shift) then copies the byte into a separate frame shift register. The register sends a low start bit, the data bits least significant first, an optional even or odd parity bit, and a high stop bit. While nothing is being sent the line stays high.

The block runs entirely from a clock at `OVERSAMPLE` (16 by default) times the baud rate. An internal divider, restarted at each load, makes every serial bit last exactly `OVERSAMPLE` clock cycles. The empty flag goes high again as soon as the latch has been copied, so software can queue the next byte while the current frame is still on the line. That next byte goes out right after the current stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1 and `hold_empty` is 1. Whenever no frame is being shifted, `txd` is 1.
- R2: A frame is sent in this order: start bit 0, then data bit 0 up to data bit 7, then the parity bit if enabled, then one stop bit of value 1.
- R3: Each serial bit holds `txd` constant for exactly `OVERSAMPLE` (16) clock cycles.
- R4: With `par_en`=1 and `par_odd`=0, the parity bit makes the count of ones over data and parity even.
- R5: With `par_en`=1 and `par_odd`=1, the parity bit makes the count of ones over data and parity odd.
- R6: With `par_en`=0, no parity bit is sent, and the stop bit directly follows data bit 7 (10 bits per frame).
- R7: A strobe sampled while `hold_empty`=1 captures `wr_data` and drops `hold_empty` in the next cycle. The start bit appears on `txd` two cycles after that capture edge.
- R8: `hold_empty` returns to 1 in the same cycle the start bit appears. A byte written during a frame starts its own start bit 2 cycles after the previous stop bit ends.
- R9: A strobe sampled while `hold_empty`=0 is ignored. The flag stays 0, and the queued byte (not the ignored one) is the next one sent.
- R10: The controller moves from idle to load to shift and back to idle. It never enters shift directly from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk16 | input | 1 | Clock at OVERSAMPLE times the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Byte to transmit |
| wr_stb | input | 1 | Write strobe, one cycle |
| par_en | input | 1 | 1 inserts a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| txd | output | 1 | Serial output, high when idle |
| hold_empty | output | 1 | 1 when the holding latch can accept a byte |

## Verification
A wrong divider count shows up within the first frame: every bit edge after the start bit falls off its 16-cycle grid, which the checks at the first, middle and last cycle of each bit detect. A corrupted shift register or parity term shows up at the middle sample of the wrong bit. A latch that accepts a write while full shows up one frame later, when the following frame carries the overwritten byte. A flag or controller error shows up within two cycles of a write, as a wrong `hold_empty` level or a misplaced start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_LOAD  = 2'd1,
      TX_SHIFT = 2'd2
   } tx_state_e;
endpackage

// File: rtl/tx_baud_div.sv
module tx_baud_div #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (OVERSAMPLE >= 2) else $error("OVERSAMPLE must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clear)      cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   assign tick = !clear && (cnt_q == LAST);

   // R3: bit periods never collapse into back-to-back ticks
   a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/tx_hold_latch.sv
module tx_hold_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full   <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_stb && !full) begin
         hold_q <= wr_data;
         full   <= 1'b1;
      end
   end

   a_r7_capture_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !full) |=> full);

   a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && full) |=> $stable(hold_q));

   a_r8_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !full);
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
   import uart_tx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int STOP_BITS      = 1,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              tick,
   output logic              take,
   output logic              div_clear,
   output logic              txd
);
   localparam int FW    = 1 + DATA_W + 1 + STOP_BITS;
   localparam int CNT_W = $clog2(FW + 1);

   tx_state_e        state_q;
   logic [FW-1:0]    shreg_q;
   logic [FW-1:0]    frame_d;
   logic [CNT_W-1:0] bitcnt_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] last_d;
   logic             use_par;
   logic             par_bit;

   initial begin
      assert (STOP_BITS >= 1 && STOP_BITS <= 2) else $error("STOP_BITS must be 1 or 2");
   end

   generate
      if (PARITY_SUPPORT) begin : g_parity
         assign use_par = par_en;
         assign par_bit = (^hold_q) ^ par_odd;
      end else begin : g_no_parity
         logic unused_cfg;
         assign unused_cfg = par_en ^ par_odd;
         assign use_par = 1'b0;
         assign par_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      frame_d             = '1;
      frame_d[0]          = 1'b0;
      frame_d[DATA_W:1]   = hold_q;
      if (use_par) frame_d[DATA_W+1] = par_bit;
      last_d = use_par ? CNT_W'(FW - 1) : CNT_W'(FW - 2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TX_IDLE;
         shreg_q  <= '1;
         bitcnt_q <= '0;
         last_q   <= '0;
      end else begin
         unique case (state_q)
            TX_IDLE: if (hold_full) state_q <= TX_LOAD;
            TX_LOAD: begin
               shreg_q  <= frame_d;
               bitcnt_q <= '0;
               last_q   <= last_d;
               state_q  <= TX_SHIFT;
            end
            TX_SHIFT: if (tick) begin
               if (bitcnt_q == last_q) begin
                  state_q <= TX_IDLE;
               end else begin
                  shreg_q  <= {1'b1, shreg_q[FW-1:1]};
                  bitcnt_q <= bitcnt_q + 1'b1;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign take      = (state_q == TX_LOAD);
   assign div_clear = (state_q != TX_SHIFT);
   assign txd       = (state_q == TX_SHIFT) ? shreg_q[0] : 1'b1;

   a_r1_line_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != TX_SHIFT) |-> txd);

   a_r2_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_LOAD) |=> (state_q == TX_SHIFT && !txd));

   a_r2_last_bit_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_SHIFT && tick && bitcnt_q == last_q) |-> txd);

   a_r10_no_idle_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_IDLE) |=> (state_q != TX_SHIFT));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter int STOP_BITS      = 1,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk16,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              txd,
   output logic              hold_empty
);
   logic              take;
   logic              div_clear;
   logic              tick;
   logic              full;
   logic [DATA_W-1:0] hold_q;

   initial begin
      assert (DATA_W >= 5 && DATA_W <= 8) else $error("DATA_W must be 5..8");
   end

   tx_hold_latch #(.DATA_W(DATA_W)) i_latch (
      .clk(clk16), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .take(take), .hold_q(hold_q), .full(full)
   );

   tx_baud_div #(.OVERSAMPLE(OVERSAMPLE)) i_div (
      .clk(clk16), .rst_n(rst_n), .clear(div_clear), .tick(tick)
   );

   tx_frame_shift #(
      .DATA_W(DATA_W), .STOP_BITS(STOP_BITS), .PARITY_SUPPORT(PARITY_SUPPORT)
   ) i_shift (
      .clk(clk16), .rst_n(rst_n), .hold_full(full), .hold_q(hold_q),
      .par_en(par_en), .par_odd(par_odd), .tick(tick),
      .take(take), .div_clear(div_clear), .txd(txd)
   );

   assign hold_empty = !full;

   a_r8_empty_with_start: assert property (@(posedge clk16) disable iff (!rst_n)
      take |=> (hold_empty && !txd));
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
   logic       clk16 = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_stb = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       txd;
   logic       hold_empty;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   uart_frame_tx i_uart_frame_tx (
      .clk16(clk16), .rst_n(rst_n), .wr_data(wr_data), .wr_stb(wr_stb),
      .par_en(par_en), .par_odd(par_odd), .txd(txd), .hold_empty(hold_empty)
   );

   always #2.5 clk16 = ~clk16;

   function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic pe, input logic po);
      logic [11:0] b;
      b      = '1;
      b[0]   = 1'b0;
      b[8:1] = d;
      if (pe) b[9] = (^d) ^ po;
      return b;
   endfunction

   function automatic int frame_len(input logic pe);
      return pe ? 11 : 10;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Called at the negedge just after the start edge. Optionally queues a
   // byte during bit 1 and tries an overwrite during bit 2 (R8, R9).
   task automatic watch_frame(input logic [11:0] bits, input int nb,
                              input bit queue, input logic [7:0] qdata,
                              input logic [7:0] bad);
      for (int j = 0; j < 16*nb; j++) begin
         int k = j / 16;
         int o = j % 16;
         if (j > 0) @(negedge clk16);
         if (o == 0 || o == 8 || o == 15) begin
            if (k == 0)            check("R2 start bit", txd, bits[k]);
            else if (k == nb - 1)  check("R2 stop bit", txd, bits[k]);
            else if (o == 15)      check("R3 bit length", txd, bits[k]);
            else                   check(bits[9] !== 1'b1 || nb == 11 ? "R2/R4/R5 data or parity" : "R2 data", txd, bits[k]);
         end
         if (queue) begin
            if (j == 20) begin wr_data = qdata; wr_stb = 1'b1; end
            if (j == 21) begin wr_stb = 1'b0; check("R7 flag drops on queued write", hold_empty, 1'b0); end
            if (j == 40) begin wr_data = bad; wr_stb = 1'b1; end
            if (j == 41) begin wr_stb = 1'b0; check("R9 flag stays low on ignored write", hold_empty, 1'b0); end
         end
      end
   endtask

   // Write a byte from idle and watch it to the end of its stop bit.
   task automatic send_idle(input logic [7:0] d, input logic pe, input logic po,
                            input bit queue, input logic [7:0] qdata, input logic [7:0] bad);
      par_en = pe; par_odd = po;
      @(negedge clk16);
      wr_data = d; wr_stb = 1'b1;
      @(posedge clk16);
      @(negedge clk16);
      wr_stb = 1'b0;
      check("R7 flag low after write", hold_empty, 1'b0);
      check("R1 line high before start", txd, 1'b1);
      @(negedge clk16);
      check("R7 no start bit yet", txd, 1'b1);
      @(negedge clk16);
      check("R8 flag back high with start", hold_empty, 1'b1);
      watch_frame(frame_bits(d, pe, po), frame_len(pe), queue, qdata, bad);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk16);
      check("R1 reset txd", txd, 1'b1);
      check("R1 reset flag", hold_empty, 1'b1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk16);
      check("R1 idle line", txd, 1'b1);

      // Directed: no parity (R6), even (R4), odd (R5)
      send_idle(8'hA5, 1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk16); check("R6 idle after 10 bits", txd, 1'b1);
      send_idle(8'h03, 1'b1, 1'b0, 1'b0, '0, '0);
      @(negedge clk16); check("R4 idle after parity frame", txd, 1'b1);
      send_idle(8'h03, 1'b1, 1'b1, 1'b0, '0, '0);
      @(negedge clk16); check("R5 idle after parity frame", txd, 1'b1);
      send_idle(8'h00, 1'b1, 1'b1, 1'b0, '0, '0);
      @(negedge clk16);
      send_idle(8'hFF, 1'b1, 1'b0, 1'b0, '0, '0);
      @(negedge clk16);

      // Back-to-back with an ignored overwrite (R8, R9)
      send_idle(8'h5C, 1'b1, 1'b0, 1'b1, 8'h96, 8'h0F);
      @(negedge clk16);
      check("R8 gap cycle 1 high", txd, 1'b1);
      @(negedge clk16);
      check("R10 load cycle high", txd, 1'b1);
      @(negedge clk16);
      check("R8 queued start on time", txd, 1'b0);
      watch_frame(frame_bits(8'h96, 1'b1, 1'b0), 11, 1'b0, '0, '0);
      @(negedge clk16);
      check("R9 no extra frame from ignored byte", txd, 1'b1);
      repeat (20) @(negedge clk16);
      check("R9 line stays idle", txd, 1'b1);
      check("R9 flag high", hold_empty, 1'b1);

      // Random frames, some queued back to back
      for (int i = 0; i < 24; i++) begin
         logic [7:0] d  = 8'($urandom);
         logic [7:0] q  = 8'($urandom);
         logic       pe = 1'($urandom);
         logic       po = 1'($urandom);
         bit         qu = (($urandom % 3) == 0);
         send_idle(d, pe, po, qu, q, ~q);
         if (qu) begin
            repeat (3) @(negedge clk16);
            check("R8 queued start", txd, 1'b0);
            watch_frame(frame_bits(q, pe, po), frame_len(pe), 1'b0, '0, '0);
         end
         repeat (1 + ($urandom % 4)) @(negedge clk16);
         check("R1 idle between frames", txd, 1'b1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule